// File: doc/BRIEF.md
# Programmable Floating-Point Comparator

This block compares two floating-point operands held in a parameterized format (one sign bit, an exponent field, a stored fraction field with hidden leading one). A 6-bit operation code, sampled with the operands, picks what the block answers. It can evaluate one of seven relational predicates, returning true or false in bit 0 of the result. It can also report a one-hot condition code in the low four result bits. Operands whose exponent field is zero count as zeros of their own sign. Any NaN operand makes the pair unordered.

Operands enter under a new-data / ready-for-data handshake and leave as a registered result with a one-cycle result-ready strobe, after a fixed latency. The pipeline accepts one operation per cycle. A clock enable freezes the whole block. A synchronous clear empties the control path and discards work in flight. It is meant to sit between registered producers and consumers inside a larger datapath.

Top module: `fpcmp`

## Requirements
- R1: Predicate codes on `op`: 6'b001100 less-than, 6'b011100 less-or-equal, 6'b010100 equal, 6'b101100 not-equal, 6'b100100 greater-than, 6'b110100 greater-or-equal, 6'b000100 unordered. The answer is in `res[0]` (1 true, 0 false), and `res` bits above 0 are zero.
- R2: Code 6'b111100 selects condition-code mode. `res[3:0]` is one-hot: bit 0 equal, bit 1 a<b, bit 2 a>b, bit 3 unordered. `res` bits above 3 are zero.
- R3: A NaN is an operand with an all-ones exponent and a non-zero fraction. If either operand is a NaN, the pair is unordered. Then the unordered and not-equal predicates are true, every other predicate is false, and the condition code is 4'b1000.
- R4: An operand with a zero exponent field counts as zero. +0 and -0 compare equal. A non-zero fraction with a zero exponent (a denormal) compares equal to either zero.
- R5: An infinity has an all-ones exponent and a zero fraction. +inf is greater than every finite value, -inf is less than every finite value, and two infinities of the same sign compare equal.
- R6: For negative operands, order is reversed in magnitude. Any negative non-zero value is less than any positive value or zero.
- R7: Any `op` value not listed in R1 or R2 yields an all-zero result.
- R8: An operation is accepted on a rising edge where `in_valid`, `in_ready` and `ce` are all high. Its result and a single-cycle `res_valid` pulse appear after LAT rising edges with `ce` high, counting the accepting edge (default LAT=2). One operation per cycle is sustained.
- R9: While `ce` is low and `clr` is low, no operation is accepted and `in_ready`, `res_valid` and `res` hold their values.
- R10: `clr` takes priority over `ce`. An edge with `clr` high drops `in_ready` and `res_valid` low and discards operations in flight. `in_ready` returns high on the first edge with `clr` low and `ce` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| clr | input | 1 | Synchronous clear of the control path, active high |
| ce | input | 1 | Clock enable, active high |
| in_valid | input | 1 | Operands and operation code are valid |
| in_ready | output | 1 | Block can take new operands |
| a | input | 1+EXP_W+FRAC_W | Operand A |
| b | input | 1+EXP_W+FRAC_W | Operand B |
| op | input | 6 | Predicate or condition-code selector |
| res | output | 1+EXP_W+FRAC_W | Comparison result |
| res_valid | output | 1 | Result-ready strobe, one cycle per accepted operation |

## Verification
On every cycle, the assertions check four things. The internal condition code is exactly one-hot whenever an operation sits in the first stage. A valid result never has bits set above the condition-code field. A low clock enable freezes the outputs. Ready stays high until a clear, and a clear leaves both handshake outputs low. Only the directed scenarios can show that the right relation is computed for each operand class (signed zeros, denormals, infinities, NaNs, negative operands), that each code maps to the right predicate, that the latency is exact with back-to-back issue, and that in-flight work is dropped by a clear.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

  localparam logic [5:0] OP_UNORD = 6'b000100;
  localparam logic [5:0] OP_LT    = 6'b001100;
  localparam logic [5:0] OP_EQ    = 6'b010100;
  localparam logic [5:0] OP_LE    = 6'b011100;
  localparam logic [5:0] OP_GT    = 6'b100100;
  localparam logic [5:0] OP_NE    = 6'b101100;
  localparam logic [5:0] OP_GE    = 6'b110100;
  localparam logic [5:0] OP_CC    = 6'b111100;

  // one-hot relation code: [0] equal, [1] less, [2] greater, [3] unordered
  typedef struct packed {
    logic unord;
    logic gt;
    logic lt;
    logic eq;
  } rel_t;

  typedef struct packed {
    logic sign;
    logic is_nan;
    logic is_inf;
    logic is_zero;
  } fcls_t;

  function automatic logic pick_pred(input logic [5:0] code, input rel_t r);
    logic hit;
    case (code)
      OP_UNORD: hit = r.unord;
      OP_LT:    hit = r.lt;
      OP_EQ:    hit = r.eq;
      OP_LE:    hit = r.lt | r.eq;
      OP_GT:    hit = r.gt;
      OP_NE:    hit = ~r.eq;
      OP_GE:    hit = r.gt | r.eq;
      default:  hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify
  import fpcmp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W,
  localparam int MAG_W = EXP_W + FRAC_W
) (
  input  logic [W-1:0]     val,
  output fcls_t            cls,
  output logic [MAG_W-1:0] mag
);
  logic [EXP_W-1:0]  ex;
  logic [FRAC_W-1:0] fr;
  logic ex_max, ex_min, fr_nz;

  assign ex     = val[W-2 -: EXP_W];
  assign fr     = val[FRAC_W-1:0];
  assign ex_max = &ex;
  assign ex_min = ~|ex;
  assign fr_nz  = |fr;

  assign cls.sign    = val[W-1];
  assign cls.is_nan  = ex_max & fr_nz;
  assign cls.is_inf  = ex_max & ~fr_nz;
  assign cls.is_zero = ex_min;           // denormals flush to signed zero
  assign mag         = ex_min ? '0 : val[MAG_W-1:0];
endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order
  import fpcmp_pkg::*;
#(
  parameter int MAG_W = 31
) (
  input  fcls_t            ca,
  input  fcls_t            cb,
  input  logic [MAG_W-1:0] ma,
  input  logic [MAG_W-1:0] mb,
  output rel_t             rel
);
  logic un, eq, lt, mag_lt, mag_gt;

  assign mag_lt = ma < mb;
  assign mag_gt = ma > mb;
  assign un     = ca.is_nan | cb.is_nan;
  assign eq     = ~un & ((ca.is_zero & cb.is_zero) |
                         ((ca.sign == cb.sign) & (ma == mb)));
  always_comb begin
    if (un || eq)               lt = 1'b0;
    else if (ca.sign != cb.sign) lt = ca.sign;
    else if (ca.sign)            lt = mag_gt;
    else                         lt = mag_lt;
  end

  assign rel.unord = un;
  assign rel.eq    = eq;
  assign rel.lt    = lt;
  assign rel.gt    = ~un & ~eq & ~lt;
endmodule

// File: rtl/fpcmp_select.sv
module fpcmp_select
  import fpcmp_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [5:0]   code,
  input  rel_t         rel,
  output logic [W-1:0] word
);
  always_comb begin
    word = '0;
    if (code == OP_CC) word[3:0] = rel;
    else               word[0]   = pick_pred(code, rel);
  end
endmodule

// File: rtl/fpcmp_ctrl.sv
module fpcmp_ctrl #(
  parameter int LAT = 2
) (
  input  logic           clk,
  input  logic           clr,
  input  logic           ce,
  input  logic           in_valid,
  output logic           in_ready,
  output logic           accept,
  output logic [LAT-1:0] stage_vld
);
  logic           rdy_q;
  logic [LAT-1:0] vld_q;

  assign accept    = in_valid & rdy_q & ce & ~clr;
  assign in_ready  = rdy_q;
  assign stage_vld = vld_q;

  always_ff @(posedge clk) begin
    if (clr)     rdy_q <= 1'b0;
    else if (ce) rdy_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (clr)     vld_q <= '0;
    else if (ce) vld_q <= {vld_q[LAT-2:0], accept};
  end
endmodule

// File: rtl/fpcmp.sv
module fpcmp
  import fpcmp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int LAT    = 2
) (
  input  logic                    clk,
  input  logic                    clr,
  input  logic                    ce,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [EXP_W+FRAC_W:0]   a,
  input  logic [EXP_W+FRAC_W:0]   b,
  input  logic [5:0]              op,
  output logic [EXP_W+FRAC_W:0]   res,
  output logic                    res_valid
);
  localparam int W     = 1 + EXP_W + FRAC_W;
  localparam int MAG_W = EXP_W + FRAC_W;
  localparam int NPIPE = LAT - 1;

  // ---- operand classification ----
  fcls_t            cls [2];
  logic [MAG_W-1:0] mag [2];
  logic [W-1:0]     opnd [2];
  assign opnd[0] = a;
  assign opnd[1] = b;

  for (genvar i = 0; i < 2; i++) begin : g_cls
    fpcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .val(opnd[i]), .cls(cls[i]), .mag(mag[i])
    );
  end

  rel_t rel_s0;
  fpcmp_order #(.MAG_W(MAG_W)) u_ord (
    .ca(cls[0]), .cb(cls[1]), .ma(mag[0]), .mb(mag[1]), .rel(rel_s0)
  );

  // ---- control ----
  logic           accept;
  logic [LAT-1:0] stage_vld;
  fpcmp_ctrl #(.LAT(LAT)) u_ctrl (
    .clk(clk), .clr(clr), .ce(ce), .in_valid(in_valid),
    .in_ready(in_ready), .accept(accept), .stage_vld(stage_vld)
  );

  // ---- stage 1: relation code and operation ----
  rel_t       cc_s1;
  logic [5:0] op_s1;
  always_ff @(posedge clk) begin
    if (accept) begin
      cc_s1 <= rel_s0;
      op_s1 <= op;
    end
  end

  logic [W-1:0] word_s1;
  fpcmp_select #(.W(W)) u_sel (.code(op_s1), .rel(cc_s1), .word(word_s1));

  // ---- result delay line, each stage loads only with a valid token ----
  logic [W-1:0] pipe_q [NPIPE];
  for (genvar k = 0; k < NPIPE; k++) begin : g_pipe
    if (k == 0) begin : g_head
      always_ff @(posedge clk)
        if (ce && !clr && stage_vld[0]) pipe_q[0] <= word_s1;
    end else begin : g_tail
      always_ff @(posedge clk)
        if (ce && !clr && stage_vld[k]) pipe_q[k] <= pipe_q[k-1];
    end
  end

  assign res       = pipe_q[NPIPE-1];
  assign res_valid = stage_vld[LAT-1];
endmodule

// File: rtl/fpcmp_checks.sv
module fpcmp_checks #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         clr,
  input logic         ce,
  input logic         in_ready,
  input logic         res_valid,
  input logic [W-1:0] res,
  input logic [3:0]   cc_s1,
  input logic         vld_s1
);
  // R2, R3: relation code in stage 1 is exactly one-hot for a live token
  p_cc_onehot_r2: assert property (@(posedge clk) disable iff (clr)
    vld_s1 |-> ($countones(cc_s1) == 1));

  // R1, R2, R7: nothing above the condition-code field is ever set
  p_upper_zero_r1: assert property (@(posedge clk) disable iff (clr)
    res_valid |-> (res[W-1:4] == '0));

  // R9: a low enable freezes the outputs
  p_ce_hold_r9: assert property (@(posedge clk) disable iff (clr)
    !ce |=> ($stable(res) && $stable(res_valid) && $stable(in_ready)));

  // R10: ready, once up, stays up until a clear
  p_ready_sticky_r10: assert property (@(posedge clk) disable iff (clr)
    in_ready |=> in_ready);

  // R10: after a clear edge both handshake outputs are low
  p_clr_drops_r10: assert property (@(posedge clk) disable iff (clr)
    $past(clr) |-> (!in_ready && !res_valid));
endmodule

bind fpcmp fpcmp_checks #(.W(1 + EXP_W + FRAC_W)) u_checks (
  .clk(clk), .clr(clr), .ce(ce), .in_ready(in_ready),
  .res_valid(res_valid), .res(res), .cc_s1(cc_s1), .vld_s1(stage_vld[0])
);

// File: tb/fpcmp_bench.sv
module fpcmp_bench;
  logic        clk = 1'b0;
  logic        clr = 1'b1;
  logic        ce = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] a = '0, b = '0, res;
  logic [5:0]  op = '0;
  logic        res_valid;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  fpcmp u_fpcmp (
    .clk(clk), .clr(clr), .ce(ce), .in_valid(in_valid), .in_ready(in_ready),
    .a(a), .b(b), .op(op), .res(res), .res_valid(res_valid)
  );

  localparam logic [31:0] P1 = 32'h3F800000, P2 = 32'h40000000;
  localparam logic [31:0] N1 = 32'hBF800000, N2 = 32'hC0000000;
  localparam logic [31:0] PZ = 32'h00000000, NZ = 32'h80000000;
  localparam logic [31:0] PD = 32'h00000001, ND = 32'h807FFFFF;
  localparam logic [31:0] PI = 32'h7F800000, NI = 32'hFF800000;
  localparam logic [31:0] QN = 32'h7FC00000, SN = 32'hFF800001;
  localparam logic [31:0] BIG = 32'h7F7FFFFF;

  // independent reference: map to a signed integer line, NaN apart
  function automatic logic is_nan32(input logic [31:0] v);
    return (v[30:23] == 8'hFF) && (v[22:0] != 0);
  endfunction
  function automatic longint line_pos(input logic [31:0] v);
    longint m;
    m = (v[30:23] == 8'h00) ? 64'sd0 : longint'({33'd0, v[30:0]});
    return v[31] ? -m : m;
  endfunction
  function automatic logic [3:0] ref_cc(input logic [31:0] x, input logic [31:0] y);
    if (is_nan32(x) || is_nan32(y)) return 4'b1000;
    if (line_pos(x) < line_pos(y)) return 4'b0010;
    if (line_pos(x) > line_pos(y)) return 4'b0100;
    return 4'b0001;
  endfunction
  function automatic logic [31:0] ref_res(input logic [5:0] c, input logic [3:0] r);
    case (c)
      6'b111100: return {28'd0, r};
      6'b000100: return {31'd0, r == 4'b1000};
      6'b001100: return {31'd0, r == 4'b0010};
      6'b010100: return {31'd0, r == 4'b0001};
      6'b011100: return {31'd0, (r == 4'b0010) || (r == 4'b0001)};
      6'b100100: return {31'd0, r == 4'b0100};
      6'b101100: return {31'd0, r != 4'b0001};
      6'b110100: return {31'd0, (r == 4'b0100) || (r == 4'b0001)};
      default:   return 32'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one isolated operation, checked at the cycle the result must appear
  task automatic one_op(input string tag, input logic [31:0] x, input logic [31:0] y,
                        input logic [5:0] c, input logic [31:0] exp);
    @(negedge clk);
    a = x; b = y; op = c; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check({tag, " valid"}, {31'd0, res_valid}, 32'd1);
    check(tag, res, exp);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check("R10 ready during clear", {31'd0, in_ready}, 32'd0);
    check("R10 valid during clear", {31'd0, res_valid}, 32'd0);
    clr = 1'b0;
    @(negedge clk);
    check("R10 ready after clear", {31'd0, in_ready}, 32'd1);
  endtask

  task automatic t_predicates;
    logic [5:0] codes [7];
    codes = '{6'b000100, 6'b001100, 6'b010100, 6'b011100,
              6'b100100, 6'b101100, 6'b110100};
    foreach (codes[i]) begin
      one_op("R1 1<2",  P1, P2, codes[i], ref_res(codes[i], ref_cc(P1, P2)));
      one_op("R1 2>1",  P2, P1, codes[i], ref_res(codes[i], ref_cc(P2, P1)));
      one_op("R1 1==1", P1, P1, codes[i], ref_res(codes[i], ref_cc(P1, P1)));
    end
    one_op("R1 LT literal", P1, P2, 6'b001100, 32'd1);
    one_op("R1 GE literal", P1, P2, 6'b110100, 32'd0);
  endtask

  task automatic t_ccode;
    one_op("R2 cc less",    N1, P1, 6'b111100, 32'h2);
    one_op("R2 cc greater", P2, N2, 6'b111100, 32'h4);
    one_op("R2 cc equal",   N2, N2, 6'b111100, 32'h1);
  endtask

  task automatic t_nan;
    one_op("R3 cc nan",     QN, P1, 6'b111100, 32'h8);
    one_op("R3 cc nan b",   P1, SN, 6'b111100, 32'h8);
    one_op("R3 NE nan",     QN, QN, 6'b101100, 32'd1);
    one_op("R3 UN nan",     PI, QN, 6'b000100, 32'd1);
    one_op("R3 EQ nan",     QN, QN, 6'b010100, 32'd0);
    one_op("R3 LE nan",     SN, P1, 6'b011100, 32'd0);
    one_op("R3 GE nan",     P1, QN, 6'b110100, 32'd0);
    one_op("R3 UN ordered", P1, P2, 6'b000100, 32'd0);
  endtask

  task automatic t_zero;
    one_op("R4 +0 == -0",      PZ, NZ, 6'b010100, 32'd1);
    one_op("R4 denorm == 0",   PD, NZ, 6'b111100, 32'h1);
    one_op("R4 -denorm == +d", ND, PD, 6'b010100, 32'd1);
    one_op("R4 denorm < 1",    ND, P1, 6'b001100, 32'd1);
  endtask

  task automatic t_inf;
    one_op("R5 +inf > max",  PI, BIG, 6'b100100, 32'd1);
    one_op("R5 -inf < -max", NI, {1'b1, BIG[30:0]}, 6'b001100, 32'd1);
    one_op("R5 -inf < +inf", NI, PI, 6'b111100, 32'h2);
    one_op("R5 inf == inf",  PI, PI, 6'b010100, 32'd1);
  endtask

  task automatic t_negative;
    one_op("R6 -2 < -1",  N2, N1, 6'b001100, 32'd1);
    one_op("R6 -1 > -2",  N1, N2, 6'b111100, 32'h4);
    one_op("R6 -1 < +0",  N1, PZ, 6'b001100, 32'd1);
    one_op("R6 -0 > -1",  NZ, N1, 6'b100100, 32'd1);
  endtask

  task automatic t_unknown;
    one_op("R7 op 000000", P1, P2, 6'b000000, 32'd0);
    one_op("R7 op 111111", QN, P1, 6'b111111, 32'd0);
  endtask

  task automatic t_latency;
    logic [31:0] xs [3], ys [3];
    logic [5:0]  cs [3];
    xs = '{P1, NI, QN}; ys = '{P2, N1, P1}; cs = '{6'b111100, 6'b001100, 6'b101100};
    @(negedge clk);
    foreach (xs[i]) begin
      a = xs[i]; b = ys[i]; op = cs[i]; in_valid = 1'b1;
      @(negedge clk);
      if (i == 0) check("R8 no result after one edge", {31'd0, res_valid}, 32'd0);
      else        check("R8 stream result", res, ref_res(cs[i-1], ref_cc(xs[i-1], ys[i-1])));
    end
    in_valid = 1'b0;
    @(negedge clk);
    check("R8 stream last", res, ref_res(cs[2], ref_cc(xs[2], ys[2])));
    check("R8 stream valid", {31'd0, res_valid}, 32'd1);
    @(negedge clk);
    check("R8 single pulse", {31'd0, res_valid}, 32'd0);
  endtask

  task automatic t_enable;
    // offered while disabled: never accepted
    @(negedge clk);
    a = P1; b = P2; op = 6'b111100; in_valid = 1'b1; ce = 1'b0;
    @(negedge clk);
    in_valid = 1'b0; ce = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 no accept while disabled", {31'd0, res_valid}, 32'd0);
    // in flight, then frozen
    a = N2; b = P1; op = 6'b111100; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; ce = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 frozen valid", {31'd0, res_valid}, 32'd0);
    check("R9 frozen ready", {31'd0, in_ready}, 32'd1);
    ce = 1'b1;
    @(negedge clk);
    check("R9 resumes valid", {31'd0, res_valid}, 32'd1);
    check("R9 resumes result", res, 32'h2);
    ce = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 valid held", {31'd0, res_valid}, 32'd1);
    ce = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_clear;
    @(negedge clk);
    a = P2; b = P1; op = 6'b100100; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; clr = 1'b1; ce = 1'b0;
    @(negedge clk);
    check("R10 clear over ce ready", {31'd0, in_ready}, 32'd0);
    check("R10 clear drops valid", {31'd0, res_valid}, 32'd0);
    clr = 1'b0; ce = 1'b1;
    @(negedge clk);
    check("R10 ready back", {31'd0, in_ready}, 32'd1);
    check("R10 in-flight discarded", {31'd0, res_valid}, 32'd0);
    @(negedge clk);
    check("R10 no late result", {31'd0, res_valid}, 32'd0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      checks++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_predicates();
    t_ccode();
    t_nan();
    t_zero();
    t_inf();
    t_negative();
    t_unknown();
    t_latency();
    t_enable();
    t_clear();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule